// File: doc/BRIEF.md
# Tearing-Effect Sync Pulse Detector

A display panel signals its refresh position on one tearing-effect line. Vertical-sync and horizontal-sync pulses share that line, and this block tells them apart by pulse width alone. Each pulse is timed in ticks of a programmable clock divider and compared against two thresholds. A pulse that reaches the vertical threshold is a VS. A pulse that reaches only the horizontal threshold is an HS. A pulse shorter than both is dropped as a glitch. Each class has its own polarity setting.

After every VS the block counts lines, one per HS. It emits an active-low, single-cycle match strobe when the selected mode's condition is met. A frame-transfer engine takes the falling edge of that strobe as the moment to release a pending frame. All configuration comes in as static register fields driven by the surrounding register file.

Top module: `te_sync_detect`

## Requirements
- R1: While reset is asserted and after its release, match_no is high, hs_det_o and vs_det_o are low and line_cnt_o is 0.
- R2: A clk_div_i value d gives a tick of d+1 clock cycles. The measured width of a pulse is floor(N/(d+1)) ticks, where N is the number of clock cycles the pulse is active. The count saturates at the all-ones threshold value.
- R3: A pulse whose measured width is at least vs_thr_i gives exactly one vs_det_o strobe.
- R4: A pulse whose measured width is at least hs_thr_i and below vs_thr_i gives exactly one hs_det_o strobe.
- R5: A pulse whose measured width is below both thresholds gives no strobe and leaves line_cnt_o unchanged.
- R6: The active level of te_i is high for HS measurement when hs_inv_i=0 and low when hs_inv_i=1. The same rule applies to VS measurement with vs_inv_i.
- R7: A VS strobe sets line_cnt_o to 0. An HS strobe adds 1 to it, and the count saturates at 2047.
- R8: With mode_i=3, match_no pulses low together with every vs_det_o and never for an HS.
- R9: With mode_i=2, match_no pulses low together with an HS or VS strobe when the updated line_cnt_o equals line_i.
- R10: With mode_i=0 or mode_i=1, match_no stays high.
- R11: While en_i is low there are no strobes, line_cnt_o is 0 and match_no is high.
- R12: Every low pulse on match_no lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Tearing logic enable |
| mode_i | input | 2 | 0 off, 1 reserved (off), 2 HS or VS with line match, 3 VS only |
| clk_div_i | input | 3 | Tick divider minus one (1 to 8 cycles) |
| hs_inv_i | input | 1 | HS active level is low when set |
| vs_inv_i | input | 1 | VS active level is low when set |
| hs_thr_i | input | 12 | HS minimum width in ticks |
| vs_thr_i | input | 12 | VS minimum width in ticks (8 to 4095, above hs_thr_i) |
| line_i | input | 11 | Target line for mode 2 |
| te_i | input | 1 | Tearing-effect pin from the panel |
| hs_det_o | output | 1 | One-cycle HS classification strobe |
| vs_det_o | output | 1 | One-cycle VS classification strobe |
| line_cnt_o | output | 11 | Lines counted since the last VS |
| match_no | output | 1 | Active-low one-cycle match event |

## Verification
Every divider setting is swept with pulse lengths that run from one cycle up past the VS threshold, under two threshold pairs. This exposes off-by-one errors at the glitch/HS and HS/VS boundaries and in how ticks are rounded. Fixed runs of one VS followed by HS pulses separate the mode 2 line match from mode 3 VS-only firing and from the disabled modes. A run of more than 2047 HS pulses shows the counter saturating. Pulses sent with both polarities inverted, and pulses sent with the enable cleared, show that the active level is chosen correctly and that the gate works.

// File: rtl/te_pkg.sv
package te_pkg;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned TH_W   = 12;
  localparam int unsigned LINE_W = 11;

  typedef enum logic [1:0] {
    TE_OFF     = 2'd0,
    TE_RSVD    = 2'd1,
    TE_ANY     = 2'd2,
    TE_VS_ONLY = 2'd3
  } te_mode_e;
endpackage

// File: rtl/te_tick_div.sv
module te_tick_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int unsigned DIV_W = 3,
  parameter int unsigned TH_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lvl_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             end_o,
  output logic [TH_W-1:0]  width_o
);
  logic            active, act_q, tick;
  logic [TH_W-1:0] width_q;

  assign active = en_i && lvl_i;

  // divider restarts with every pulse so width is phase-independent
  te_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .div_i  (div_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= '0;
      act_q   <= 1'b0;
    end else begin
      act_q <= active;
      if (!active)                      width_q <= '0;
      else if (tick && (width_q != '1)) width_q <= width_q + 1'b1;
    end
  end

  assign end_o   = act_q && !active && en_i;
  assign width_o = width_q;
endmodule

// File: rtl/te_line_track.sv
module te_line_track
  import te_pkg::*;
#(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              hs_hit_i,
  input  logic              vs_hit_i,
  output logic              hs_det_o,
  output logic              vs_det_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              match_no
);
  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic              hs_ev, vs_ev, fire;
  te_mode_e          mode;

  assign mode  = te_mode_e'(mode_i);
  assign vs_ev = en_i && vs_hit_i;
  assign hs_ev = en_i && hs_hit_i && !vs_hit_i;

  always_comb begin
    cnt_d = cnt_q;
    if (vs_ev)                      cnt_d = '0;
    else if (hs_ev && cnt_q != '1)  cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    unique case (mode)
      TE_ANY:     fire = (hs_ev || vs_ev) && (cnt_d == line_i);
      TE_VS_ONLY: fire = vs_ev;
      default:    fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      hs_det_o <= 1'b0;
      vs_det_o <= 1'b0;
      match_no <= 1'b1;
    end else if (!en_i) begin
      cnt_q    <= '0;
      hs_det_o <= 1'b0;
      vs_det_o <= 1'b0;
      match_no <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      hs_det_o <= hs_ev;
      vs_det_o <= vs_ev;
      match_no <= !fire;
    end
  end

  assign line_cnt_o = cnt_q;
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
  import te_pkg::*;
#(
  parameter int unsigned DIV_W  = te_pkg::DIV_W,
  parameter int unsigned TH_W   = te_pkg::TH_W,
  parameter int unsigned LINE_W = te_pkg::LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              hs_inv_i,
  input  logic              vs_inv_i,
  input  logic [TH_W-1:0]   hs_thr_i,
  input  logic [TH_W-1:0]   vs_thr_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              te_i,
  output logic              hs_det_o,
  output logic              vs_det_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              match_no
);
  localparam int unsigned NCLS = 2; // 0: HS, 1: VS

  logic [1:0]      te_sync_q;
  logic            te_s;
  logic            end_w   [NCLS];
  logic [TH_W-1:0] width_w [NCLS];
  logic            hs_hit, vs_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) te_sync_q <= '0;
    else         te_sync_q <= {te_sync_q[0], te_i};
  end
  assign te_s = te_sync_q[1];

  for (genvar g = 0; g < NCLS; g++) begin : g_meter
    logic inv;
    assign inv = (g == 1) ? vs_inv_i : hs_inv_i;
    te_pulse_meter #(.DIV_W(DIV_W), .TH_W(TH_W)) u_meter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .lvl_i   (te_s ^ inv),
      .div_i   (clk_div_i),
      .end_o   (end_w[g]),
      .width_o (width_w[g])
    );
  end

  assign vs_hit = end_w[1] && (width_w[1] >= vs_thr_i);
  assign hs_hit = end_w[0] && (width_w[0] >= hs_thr_i) && (width_w[0] < vs_thr_i);

  te_line_track #(.LINE_W(LINE_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mode_i     (mode_i),
    .line_i     (line_i),
    .hs_hit_i   (hs_hit),
    .vs_hit_i   (vs_hit),
    .hs_det_o   (hs_det_o),
    .vs_det_o   (vs_det_o),
    .line_cnt_o (line_cnt_o),
    .match_no   (match_no)
  );
endmodule

// File: rtl/te_sync_checker.sv
module te_sync_checker #(
  parameter int unsigned LINE_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [1:0]        mode_i,
  input logic [LINE_W-1:0] line_i,
  input logic              hs_det_o,
  input logic              vs_det_o,
  input logic [LINE_W-1:0] line_cnt_o,
  input logic              match_no
);
  a_r12_match_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_no |=> match_no);

  a_r11_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (match_no && !hs_det_o && !vs_det_o && line_cnt_o == '0));

  a_r3_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_det_o && vs_det_o));

  a_r7_vs_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_det_o |-> line_cnt_o == '0);

  a_r7_hs_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_det_o && $past(line_cnt_o) != '1) |-> line_cnt_o == $past(line_cnt_o) + 1'b1);

  a_r8_vs_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_no && $past(mode_i) == 2'd3) |-> vs_det_o);

  a_r9_line_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_no && $past(mode_i) == 2'd2) |-> (line_cnt_o == $past(line_i) && (hs_det_o || vs_det_o)));

  a_r10_off_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'd0 || $past(mode_i) == 2'd1) |-> match_no);
endmodule

bind te_sync_detect te_sync_checker #(.LINE_W(LINE_W)) u_te_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .mode_i     (mode_i),
  .line_i     (line_i),
  .hs_det_o   (hs_det_o),
  .vs_det_o   (vs_det_o),
  .line_cnt_o (line_cnt_o),
  .match_no   (match_no)
);

// File: tb/test_te_sync_detect.sv
`timescale 1ns/1ps
module test_te_sync_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [2:0]  div = 3'd0;
  logic        hs_inv = 1'b0, vs_inv = 1'b0;
  logic [11:0] hs_thr = 12'd2, vs_thr = 12'd8;
  logic [10:0] line = 11'd0;
  logic        te = 1'b0;
  logic        idle = 1'b0;
  logic        hs_det, vs_det, match_n;
  logic [10:0] line_cnt;

  int checks = 0, errors = 0;
  int hs_cnt = 0, vs_cnt = 0, m_cnt = 0, low_run = 0, max_low = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  te_sync_detect i_te_sync_detect (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .clk_div_i(div),
    .hs_inv_i(hs_inv), .vs_inv_i(vs_inv), .hs_thr_i(hs_thr), .vs_thr_i(vs_thr),
    .line_i(line), .te_i(te), .hs_det_o(hs_det), .vs_det_o(vs_det),
    .line_cnt_o(line_cnt), .match_no(match_n)
  );

  always @(negedge clk) begin
    if (hs_det) hs_cnt++;
    if (vs_det) vs_cnt++;
    if (!match_n) begin
      m_cnt++;
      low_run++;
      if (low_run > max_low) max_low = low_run;
    end else low_run = 0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    te = ~idle;
    repeat (n) @(negedge clk);
    te = idle;
    repeat (8) @(negedge clk);
  endtask

  // a pulse of n cycles, expected class 0 none / 1 HS / 2 VS
  task automatic pulse_check(input int n, input int cls, input string tag);
    int h0, v0;
    h0 = hs_cnt; v0 = vs_cnt;
    pulse(n);
    check((hs_cnt - h0) == (cls == 1 ? 1 : 0), {tag, " hs"}, hs_cnt - h0, cls == 1 ? 1 : 0);
    check((vs_cnt - v0) == (cls == 2 ? 1 : 0), {tag, " vs"}, vs_cnt - v0, cls == 2 ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int m0, tk, exph, expv;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(match_n === 1'b1 && !hs_det && !vs_det && line_cnt == 0, "R1 in reset", match_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(match_n === 1'b1 && !hs_det && !vs_det && line_cnt == 0, "R1 after reset", line_cnt, 0);

    // R2 R3 R4 R5 sweep: all dividers, two threshold pairs, mode 3
    en = 1'b1; mode = 2'd3;
    for (int c = 0; c < 2; c++) begin
      hs_thr = (c == 0) ? 12'd2 : 12'd5;
      vs_thr = (c == 0) ? 12'd8 : 12'd9;
      for (int d = 0; d < 8; d++) begin
        div = 3'(d);
        for (int n = 1; n <= int'(vs_thr) * (d + 1) + 1; n++) begin
          tk = n / (d + 1);
          expv = (tk >= int'(vs_thr)) ? 1 : 0;
          exph = (tk >= int'(hs_thr) && tk < int'(vs_thr)) ? 1 : 0;
          m0 = m_cnt;
          pulse_check(n, expv ? 2 : (exph ? 1 : 0), "R2 R3 R4 R5 sweep");
          check((m_cnt - m0) == expv, "R8 sweep match", m_cnt - m0, expv);
        end
      end
    end

    // R9 line match in mode 2
    div = 3'd0; hs_thr = 12'd2; vs_thr = 12'd8;
    mode = 2'd2; line = 11'd3;
    m0 = m_cnt;
    pulse_check(10, 2, "R9 vs");
    check(m_cnt == m0 && line_cnt == 0, "R9 vs no match at line 0", m_cnt - m0, 0);
    for (int k = 1; k <= 5; k++) begin
      m0 = m_cnt;
      pulse_check(4, 1, "R9 hs");
      check(line_cnt == 11'(k), "R7 hs count", line_cnt, k);
      check((m_cnt - m0) == (k == 3 ? 1 : 0), "R9 match at line", m_cnt - m0, k == 3 ? 1 : 0);
    end
    line = 11'd0;
    m0 = m_cnt;
    pulse_check(12, 2, "R9 vs line 0");
    check((m_cnt - m0) == 1 && line_cnt == 0, "R9 vs match line 0", m_cnt - m0, 1);

    // R8 mode 3: HS never matches
    mode = 2'd3;
    m0 = m_cnt;
    pulse_check(4, 1, "R8 hs");
    check(m_cnt == m0, "R8 hs no match", m_cnt - m0, 0);

    // R10 modes 0 and 1
    for (int md = 0; md < 2; md++) begin
      mode = 2'(md);
      m0 = m_cnt;
      pulse_check(10, 2, "R10 vs");
      pulse_check(4, 1, "R10 hs");
      check(m_cnt == m0, "R10 no match", m_cnt - m0, 0);
    end

    // R7 saturation and clear
    mode = 2'd0;
    pulse_check(10, 2, "R7 vs");
    for (int k = 0; k < 2050; k++) pulse(3);
    check(line_cnt == 11'd2047, "R7 saturate", line_cnt, 2047);
    pulse_check(10, 2, "R7 clear");
    check(line_cnt == 0, "R7 vs clears", line_cnt, 0);

    // R11 enable gate
    pulse(4);
    check(line_cnt == 1, "R11 pre count", line_cnt, 1);
    en = 1'b0; mode = 2'd3;
    repeat (2) @(negedge clk);
    check(line_cnt == 0, "R11 cleared", line_cnt, 0);
    m0 = m_cnt;
    pulse_check(10, 0, "R11 vs ignored");
    pulse_check(4, 0, "R11 hs ignored");
    check(m_cnt == m0 && line_cnt == 0, "R11 no match", m_cnt - m0, 0);

    // R6 inverted polarity: idle high, active low
    hs_inv = 1'b1; vs_inv = 1'b1; idle = 1'b1; te = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    m0 = m_cnt;
    pulse_check(10, 2, "R6 inverted vs");
    check((m_cnt - m0) == 1, "R6 inverted vs match", m_cnt - m0, 1);
    pulse_check(4, 1, "R6 inverted hs");
    pulse_check(1, 0, "R6 inverted glitch");
    check(line_cnt == 1, "R6 line after inverted", line_cnt, 1);

    // R12 width of match pulses over the whole run
    check(max_low == 1, "R12 match width", max_low, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule